// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block is the logic core of a clock fan-out stage. One input clock is either passed straight through or divided by 2, 4, 8 or 16, chosen by a 3-bit select code. The result drives a parameterised number of output pairs. Each pair has a true signal and its complement, and every pair carries the same waveform.

An active-low run input gates the outputs and clears the divider. This input is registered on the falling edge of the input clock, so both parking and release happen only at a falling edge. Gating at that edge cannot cut a high phase short and leave a runt pulse. Once released, the divided clocks start from a known phase. A select code change takes effect at once. It may leave one irregular period before the new ratio holds.

Top module: `clk_fanout_div`

## Requirements
- R1: With sel[2] = 0, the divider is bypassed whatever sel[1:0] holds. While enabled, every true output follows the input clock: high half-period for high, low for low.
- R2: With sel[2] = 1, sel[1:0] picks the ratio. 2'b00 divides by 2, 2'b01 by 4, 2'b10 by 8 and 2'b11 by 16. The output period is that many input periods.
- R3: Every divided output (ratio 2 or more) is high for exactly half its period. All of its transitions follow falling edges of the input clock.
- R4: run_n is sampled only at input-clock falling edges. A change that lands between two falling edges has no effect on the outputs before the next falling edge.
- R5: After a falling edge that samples run_n = 0, every out_p bit is 0 and every out_n bit is 1. This holds until a falling edge samples run_n = 1.
- R6: While parked, the divide counter is held at zero. After the falling edge that samples run_n = 1, the first rising edge of a divide-by-2^k output comes 2^(k-1) falling edges later. Before that edge the output stays low.
- R7: Each out_n bit is the complement of its out_p bit at all times. All pairs carry identical values.
- R8: After the select code changes while enabled, the output runs at the new ratio within 16 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be buffered or divided |
| sel | input | 3 | Ratio select: bit 2 low bypasses, otherwise bits 1:0 pick divide by 2/4/8/16 |
| run_n | input | 1 | Active-low park/reset request, sampled on clk_in falling edges |
| out_p | output | NUM_PAIRS | True outputs of each pair |
| out_n | output | NUM_PAIRS | Complement outputs of each pair |

## Verification
The hardest case is telling a falling-edge gate apart from one that acts at once or at the rising edge. Outputs are only visible between edges. To expose the difference, the bench moves run_n in the middle of a half period. It drops run_n just after a falling edge while bypassed, and raises it while the clock is high on a parked divider. It then samples the outputs in the half period before the next falling edge and again after it. The restart phase is measured for each ratio by counting falling edges from release to the first rising output edge.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Number of binary stages in the divide chain (highest ratio = 2**DIV_STAGES).
    localparam int unsigned DIV_STAGES = 4;

    // Select is one bypass bit plus enough bits to name one stage.
    localparam int unsigned SEL_W = 1 + $clog2(DIV_STAGES);

    // Tap index: 0 = input clock, 1..DIV_STAGES = counter bit index-1.
    localparam int unsigned TAP_W = $clog2(DIV_STAGES + 1);

    typedef struct packed {
        logic run;
    } gate_state_t;

endpackage

// File: rtl/cdiv_run_sync.sv
module cdiv_run_sync
    import cdiv_pkg::*;
(
    input  logic clk_in,
    input  logic run_n,
    output logic run_q
);

    gate_state_t state_d;
    gate_state_t state_q;

    always_comb begin
        state_d     = state_q;
        state_d.run = run_n;
    end

    // Falling-edge register: output gating only moves while clk_in is low.
    always_ff @(negedge clk_in) begin
        state_q <= state_d;
    end

    assign run_q = state_q.run;

endmodule

// File: rtl/cdiv_chain.sv
module cdiv_chain #(
    parameter int unsigned STAGES = 4
) (
    input  logic              clk_in,
    input  logic              run_n,
    input  logic              run_q,
    output logic [STAGES-1:0] count
);

    typedef struct packed {
        logic [STAGES-1:0] cnt;
    } chain_state_t;

    chain_state_t state_d;
    chain_state_t state_q;

    // Counts only when both the registered enable and the new sample are high,
    // so the counter is zero at the edge that releases and at the edge that parks.
    always_comb begin
        state_d = state_q;
        if (run_n && run_q) begin
            state_d.cnt = state_q.cnt + STAGES'(1);
        end else begin
            state_d.cnt = '0;
        end
    end

    always_ff @(negedge clk_in) begin
        state_q <= state_d;
    end

    assign count = state_q.cnt;

endmodule

// File: rtl/cdiv_tap_mux.sv
module cdiv_tap_mux
    import cdiv_pkg::*;
#(
    parameter int unsigned STAGES = 4
) (
    input  logic              clk_in,
    input  logic [SEL_W-1:0]  sel,
    input  logic [STAGES-1:0] count,
    output logic              div_clk
);

    logic [STAGES:0]  taps;
    logic [TAP_W-1:0] tap_idx;

    assign taps = {count, clk_in};

    always_comb begin
        if (sel[SEL_W-1]) begin
            tap_idx = TAP_W'(sel[SEL_W-2:0]) + TAP_W'(1);
        end else begin
            tap_idx = '0;
        end
        div_clk = taps[tap_idx];
    end

endmodule

// File: rtl/cdiv_pair_gate.sv
module cdiv_pair_gate (
    input  logic div_clk,
    input  logic run_q,
    output logic pos,
    output logic neg
);

    logic gated;

    always_comb begin
        gated = div_clk & run_q;
        pos   = gated;
        neg   = ~gated;
    end

endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div
    import cdiv_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 2
) (
    input  logic                 clk_in,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 run_n,
    output logic [NUM_PAIRS-1:0] out_p,
    output logic [NUM_PAIRS-1:0] out_n
);

    logic                  run_q;
    logic [DIV_STAGES-1:0] count;
    logic                  div_clk;

    cdiv_run_sync u_run (
        .clk_in (clk_in),
        .run_n  (run_n),
        .run_q  (run_q)
    );

    cdiv_chain #(
        .STAGES (DIV_STAGES)
    ) u_chain (
        .clk_in (clk_in),
        .run_n  (run_n),
        .run_q  (run_q),
        .count  (count)
    );

    cdiv_tap_mux #(
        .STAGES (DIV_STAGES)
    ) u_mux (
        .clk_in  (clk_in),
        .sel     (sel),
        .count   (count),
        .div_clk (div_clk)
    );

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        cdiv_pair_gate u_gate (
            .div_clk (div_clk),
            .run_q   (run_q),
            .pos     (out_p[i]),
            .neg     (out_n[i])
        );
    end

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
    import cdiv_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 2
) (
    input logic                 clk_in,
    input logic [SEL_W-1:0]     sel,
    input logic                 run_n,
    input logic [NUM_PAIRS-1:0] out_p,
    input logic [NUM_PAIRS-1:0] out_n
);

    localparam logic [SEL_W-1:0] SEL_DIV2 = {1'b1, {(SEL_W-1){1'b0}}};

    // Arms after three falling edges so every $past below has history.
    logic [1:0] arm_q = '0;
    logic       armed;

    always_ff @(negedge clk_in) begin
        if (arm_q != 2'd3) begin
            arm_q <= arm_q + 2'd1;
        end
    end

    assign armed = (arm_q == 2'd3);

    assert_bypass_high_R1: assert property (@(negedge clk_in) disable iff (!armed)
        (!sel[SEL_W-1] && $past(run_n)) |-> (out_p == '1));

    assert_half_toggle_R3: assert property (@(negedge clk_in) disable iff (!armed)
        (sel == SEL_DIV2 && $past(sel) == SEL_DIV2 && $past(run_n) && $past(run_n, 2))
        |-> (out_p[0] != $past(out_p[0])));

    assert_parked_R5: assert property (@(negedge clk_in) disable iff (!armed)
        (!$past(run_n)) |-> (out_p == '0 && out_n == '1));

    assert_pairs_match_R7: assert property (@(negedge clk_in) disable iff (!armed)
        (out_n == ~out_p) && (out_p == {NUM_PAIRS{out_p[0]}}));

endmodule

bind clk_fanout_div cdiv_checker #(
    .NUM_PAIRS (NUM_PAIRS)
) u_cdiv_checker (
    .clk_in (clk_in),
    .sel    (sel),
    .run_n  (run_n),
    .out_p  (out_p),
    .out_n  (out_n)
);

// File: tb/clk_fanout_div_bench.sv
module clk_fanout_div_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic [2:0]    sel = 3'b111;
    logic          run_n = 1'b0;
    logic [NP-1:0] out_p;
    logic [NP-1:0] out_n;

    int n_checks = 0;
    int n_fails  = 0;
    int pair_bad = 0;

    always #4ns clk = ~clk;

    clk_fanout_div #(.NUM_PAIRS(NP)) u_clk_fanout_div (
        .clk_in (clk),
        .sel    (sel),
        .run_n  (run_n),
        .out_p  (out_p),
        .out_n  (out_n)
    );

    // {sel, ratio}; order mixes bypass and divide codes to exercise switching (R8)
    localparam logic [7:0] VEC [8] = '{
        {3'b111, 5'd16}, {3'b100, 5'd2},  {3'b000, 5'd1}, {3'b110, 5'd8},
        {3'b011, 5'd1},  {3'b101, 5'd4},  {3'b001, 5'd1}, {3'b010, 5'd1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Waits for the next clock edge of either polarity, samples 2 ns later.
    task automatic step(output logic v, output bit after_fall);
        @(clk);
        after_fall = (clk == 1'b0);
        #2ns;
        v = out_p[0];
        if (out_n !== ~out_p || out_p[1] !== out_p[0]) pair_bad++;
    endtask

    task automatic measure(input logic [2:0] s, input int r);
        logic v;
        logic prev;
        bit   f;
        bit   rise_fall;
        int   hi;
        int   lo;
        sel = s;
        repeat (16) @(negedge clk);   // R8: settle window
        step(v, f);
        prev = v;
        for (int i = 0; i < 200; i++) begin
            step(v, f);
            if (!prev && v) break;
            prev = v;
        end
        rise_fall = f;
        hi = 1;
        for (int i = 0; i < 100; i++) begin
            step(v, f);
            if (!v) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 100; i++) begin
            step(v, f);
            if (v) break;
            lo++;
        end
        chk(hi + lo == 2 * r, "R2/R1/R8", $sformatf("period halves sel=%b", s), hi + lo, 2 * r);
        chk(hi == r, "R3", $sformatf("high halves sel=%b", s), hi, r);
        chk(rise_fall == (r > 1), "R3", $sformatf("rise after falling edge sel=%b", s),
            int'(rise_fall), int'(r > 1));
    endtask

    task automatic restart(input logic [2:0] s, input int exp_edges);
        int f;
        @(posedge clk); #2ns;
        run_n = 1'b0;
        sel = s;
        repeat (3) @(negedge clk);
        @(posedge clk); #2ns;
        run_n = 1'b1;                  // release mid high phase
        @(negedge clk);                // releasing edge E0
        f = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #2ns;
            f++;
            if (out_p[0]) break;
        end
        chk(f == exp_edges, "R6", $sformatf("falling edges to first rise sel=%b", s),
            f, exp_edges);
    endtask

    initial begin
        // Reset state: parked with default code
        repeat (4) @(negedge clk);
        #2ns;
        chk(out_p == 2'b00 && out_n == 2'b11, "R5", "parked outputs",
            int'({out_p, out_n}), int'(4'b0011));

        // R4: release mid high phase has no effect before the falling edge
        @(posedge clk); #2ns;
        run_n = 1'b1;
        sel = 3'b000;
        #1ns;
        chk(out_p == 2'b00, "R4", "release before falling edge", int'(out_p), 0);
        @(negedge clk); @(posedge clk); #2ns;

        // Table walk: ratio, duty and switching
        foreach (VEC[i]) measure(VEC[i][7:5], int'(VEC[i][4:0]));
        chk(pair_bad == 0, "R7", "pair/complement mismatches", pair_bad, 0);

        // R4/R5: drop run_n just after a falling edge in bypass mode
        sel = 3'b000;
        @(negedge clk); #2ns;
        run_n = 1'b0;
        @(posedge clk); #2ns;
        chk(out_p == 2'b11, "R4", "still enabled before falling edge", int'(out_p), 3);
        @(negedge clk); @(posedge clk); #2ns;
        chk(out_p == 2'b00 && out_n == 2'b11, "R5", "parked after falling edge",
            int'({out_p, out_n}), int'(4'b0011));

        // R6: restart phase for each divide ratio
        for (int k = 1; k <= 4; k++) restart({1'b1, 2'(k - 1)}, 1 << (k - 1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #800us;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule